// File: doc/BRIEF.md
# Clock-Divider Ratio Transition Sequencer

This block moves a processor clock divider from its current ratio to a requested one without breaking the DRAM that shares the clock. It owns three control fields: the 3-bit divider select, a 7-bit DRAM refresh count and a DRAM self-refresh enable. It sequences their updates in the order that the direction of the change requires, and it counts the cycles the PLL needs to lock and the cycles the refresh queue needs to drain.

A request consists of a ratio index (0..4, for divide-by 1, 2, 4, 6 and 8) and a one-cycle start strobe. Changes between divide-by-1 and any ratio above 2 are split into two steps, with divide-by-2 in between. Each step places the divider write, the refresh-count update and any self-refresh toggle in the order that keeps refresh legal. The refresh count for each ratio comes from a table built at elaboration from the core clock frequency parameter. When the sequence completes, `done_o` pulses. An illegal index pulses `err_o` instead.

Top module: `clkdiv_step_seq`

## Requirements
- R1: After reset the divider select is `000` (divide-by-1), the refresh count holds the divide-by-1 value, self-refresh is off, and `busy_o`, `done_o` and `err_o` are low. Select codes are: index 0 (div 1) `000`, index 1 (div 2) `001`, index 2 (div 4) `011`, index 3 (div 6) `010`, index 4 (div 8) `100`.
- R2: A start with an index above 4 pulses `err_o` for one cycle, the cycle after the strobe, and leaves all three control fields unchanged.
- R3: A start whose index equals the current ratio pulses `done_o` the cycle after the strobe and writes no field.
- R4: A change from divide-by-1 to divide-by 4, 6 or 8, and a change from divide-by 4, 6 or 8 to divide-by-1, runs as two steps: first to divide-by-2, then to the target.
- R5: A step from divide-by-2 to divide-by-1 clears self-refresh, then writes the divider, then updates the refresh count.
- R6: A step from divide-by-1 to divide-by-2 updates the refresh count, then writes the divider, then sets self-refresh. When idle, self-refresh is on exactly when the ratio is not divide-by-1.
- R7: Any other step that slows the clock updates the refresh count before writing the divider. Any other step that speeds it up writes the divider first and the refresh count after.
- R8: After each divider write, no field changes and `done_o` does not rise for 16 cycles (PLL lock). The next visible change comes at least 17 cycles after the divider change.
- R9: The refresh count for a divisor D is floor(CORE_HZ × 7800 / (64 × D × 10^9)).
- R10: When a slowing step updates the refresh count while self-refresh is off, the divider write waits 64 × (old count + new count) × old divisor + DRAIN_MARGIN cycles after the count update.
- R11: `busy_o` is high from the cycle after an accepted start until the sequence ends. A start while busy is ignored.
- R12: `done_o` pulses for one cycle after the last field update of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, one cycle |
| ratio_idx_i | input | 3 | Requested ratio index, 0..4 |
| div_code_o | output | 3 | Divider select field |
| refresh_cnt_o | output | 7 | DRAM refresh count field |
| self_refresh_o | output | 1 | DRAM self-refresh enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete pulse |
| err_o | output | 1 | Illegal index pulse |

## Verification
The bench replays every ordering class and compares each visible field change against a queue of expected changes, each with a minimum gap. The through-2 detours (1→8 and 6→1) catch a design that jumps straight to the target: the divide-by-2 code and the self-refresh toggle would be missing from the stream. The 1→2 step checks the drain window, which a design that skipped or mis-sized the wait would open too early. A same-index request, an illegal index and a start issued mid-sequence check that no stray write or retargeting happens, which would show up as an unexpected event or a wrong final code.

// File: rtl/clkdiv_seq_pkg.sv
package clkdiv_seq_pkg;

    localparam int unsigned NUM_RATIOS = 5;
    localparam int unsigned IDX_W      = 3;

    typedef enum logic [2:0] {
        S_IDLE, S_PLAN, S_SR_OFF, S_DIV, S_PLL, S_REF, S_DRAIN, S_SR_ON
    } seq_state_e;

    typedef enum logic [1:0] {
        K_TWO_TO_ONE, K_ONE_TO_TWO, K_SLOWER, K_FASTER
    } step_kind_e;

    function automatic logic [2:0] ratio_code(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return 3'b000;
            3'd1:    return 3'b001;
            3'd2:    return 3'b011;
            3'd3:    return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic int unsigned ratio_div(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 6;
            default: return 8;
        endcase
    endfunction

    function automatic longint unsigned refresh_for(input longint unsigned hz,
                                                    input int unsigned div);
        longint unsigned den;
        den = 64 * longint'(div) * 64'd1_000_000_000;
        return (hz * 64'd7800) / den;
    endfunction

endpackage

// File: rtl/clkdiv_step_plan.sv
module clkdiv_step_plan
    import clkdiv_seq_pkg::*;
(
    input  logic [IDX_W-1:0] cur_idx_i,
    input  logic [IDX_W-1:0] tgt_idx_i,
    output logic [IDX_W-1:0] step_idx_o,
    output step_kind_e       step_kind_o
);
    // divisor grows monotonically with index, so indices compare directly
    always_comb begin
        if ((cur_idx_i == 3'd0 && tgt_idx_i > 3'd1) ||
            (cur_idx_i > 3'd1 && tgt_idx_i == 3'd0))
            step_idx_o = 3'd1;
        else
            step_idx_o = tgt_idx_i;

        if (cur_idx_i == 3'd1 && step_idx_o == 3'd0)
            step_kind_o = K_TWO_TO_ONE;
        else if (cur_idx_i == 3'd0 && step_idx_o == 3'd1)
            step_kind_o = K_ONE_TO_TWO;
        else if (step_idx_o > cur_idx_i)
            step_kind_o = K_SLOWER;
        else
            step_kind_o = K_FASTER;
    end
endmodule

// File: rtl/clkdiv_wait_timer.sv
module clkdiv_wait_timer #(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    typedef struct packed {
        logic         active;
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign expired_o = tmr_q.active && (tmr_q.cnt == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.active = 1'b1;
            tmr_d.cnt    = load_val_i;
        end else if (expired_o) begin
            tmr_d.active = 1'b0;
        end else if (tmr_q.active) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R8: an armed count steps down by one each cycle until it expires
    a_r8_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.active && tmr_q.cnt != '0 && !load_i) |=> (tmr_q.cnt == $past(tmr_q.cnt) - 1'b1));
endmodule

// File: rtl/clkdiv_step_seq.sv
module clkdiv_step_seq
    import clkdiv_seq_pkg::*;
#(
    parameter longint unsigned CORE_HZ      = 500_000_000,
    parameter int unsigned     PLL_LOCK_CYC = 16,
    parameter int unsigned     DRAIN_MARGIN = 16,
    parameter int unsigned     REF_W        = 7,
    parameter int unsigned     TMR_W        = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       ratio_idx_i,
    output logic [2:0]       div_code_o,
    output logic [REF_W-1:0] refresh_cnt_o,
    output logic             self_refresh_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);
    localparam logic [REF_W-1:0] REF_RESET = REF_W'(refresh_for(CORE_HZ, 1));
    localparam logic [TMR_W-1:0] PLL_LOAD  = TMR_W'(PLL_LOCK_CYC - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] cur;
        logic [IDX_W-1:0] tgt;
        logic [IDX_W-1:0] step;
        step_kind_e       kind;
        logic [2:0]       code;
        logic [REF_W-1:0] rcnt;
        logic             sref;
        logic             done;
        logic             err;
    } seq_t;

    seq_t q, d;

    // refresh count per ratio, fixed at elaboration
    logic [REF_W-1:0] ref_tab [NUM_RATIOS];
    for (genvar gi = 0; gi < NUM_RATIOS; gi++) begin : g_ref_tab
        assign ref_tab[gi] = REF_W'(refresh_for(CORE_HZ, ratio_div(IDX_W'(gi))));
    end

    logic [IDX_W-1:0] plan_step;
    step_kind_e       plan_kind;
    logic             tmr_load, tmr_exp;
    logic [TMR_W-1:0] tmr_val, drain_len;
    logic             slowing;

    clkdiv_step_plan u_plan (
        .cur_idx_i  (q.cur),
        .tgt_idx_i  (q.tgt),
        .step_idx_o (plan_step),
        .step_kind_o(plan_kind)
    );

    clkdiv_wait_timer #(.W(TMR_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .expired_o (tmr_exp)
    );

    assign slowing   = (q.kind == K_ONE_TO_TWO) || (q.kind == K_SLOWER);
    assign drain_len = TMR_W'(64) * (TMR_W'(q.rcnt) + TMR_W'(ref_tab[q.step]))
                     * TMR_W'(ratio_div(q.cur)) + TMR_W'(DRAIN_MARGIN) - 1'b1;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.err    = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = PLL_LOAD;
        case (q.state)
            S_IDLE: if (start_i) begin
                if (ratio_idx_i > 3'd4)      d.err  = 1'b1;
                else if (ratio_idx_i == q.cur) d.done = 1'b1;
                else begin
                    d.tgt   = ratio_idx_i;
                    d.state = S_PLAN;
                end
            end
            S_PLAN: begin
                if (q.cur == q.tgt) begin
                    d.done  = 1'b1;
                    d.state = S_IDLE;
                end else begin
                    d.step = plan_step;
                    d.kind = plan_kind;
                    case (plan_kind)
                        K_TWO_TO_ONE: d.state = S_SR_OFF;
                        K_FASTER:     d.state = S_DIV;
                        default:      d.state = S_REF;
                    endcase
                end
            end
            S_SR_OFF: begin
                d.sref  = 1'b0;
                d.state = S_DIV;
            end
            S_DIV: begin
                d.code   = ratio_code(q.step);
                d.cur    = q.step;
                tmr_load = 1'b1;
                tmr_val  = PLL_LOAD;
                d.state  = S_PLL;
            end
            S_PLL: if (tmr_exp) begin
                case (q.kind)
                    K_ONE_TO_TWO: d.state = S_SR_ON;
                    K_SLOWER:     d.state = S_PLAN;
                    default:      d.state = S_REF;
                endcase
            end
            S_REF: begin
                d.rcnt = ref_tab[q.step];
                if (slowing && !q.sref) begin
                    tmr_load = 1'b1;
                    tmr_val  = drain_len;
                    d.state  = S_DRAIN;
                end else if (slowing) begin
                    d.state = S_DIV;
                end else begin
                    d.state = S_PLAN;
                end
            end
            S_DRAIN: if (tmr_exp) d.state = S_DIV;
            S_SR_ON: begin
                d.sref  = 1'b1;
                d.state = S_PLAN;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
            q.kind  <= K_FASTER;
            q.rcnt  <= REF_RESET;
        end else begin
            q <= d;
        end
    end

    assign div_code_o     = q.code;
    assign refresh_cnt_o  = q.rcnt;
    assign self_refresh_o = q.sref;
    assign busy_o         = (q.state != S_IDLE);
    assign done_o         = q.done;
    assign err_o          = q.err;

    // R1: only the five legal select codes ever appear
    a_r1_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (q.code != 3'b101) && (q.code != 3'b110) && (q.code != 3'b111));
    // R2: an error pulse comes with no field write
    a_r2_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> ($stable(q.code) && $stable(q.rcnt) && $stable(q.sref)));
    // R6: at rest self-refresh tracks whether the clock is divided
    a_r6_sref_at_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_IDLE) |-> (q.sref == (q.cur != 3'd0)));
    // R8: nothing moves while the PLL is locking
    a_r8_pll_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_PLL) |=> ($stable(q.code) && $stable(q.rcnt) && $stable(q.sref) && !q.done));
    // R11: a start while busy does not retarget
    a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state != S_IDLE) && start_i) |=> $stable(q.tgt));
    // R12: done and error never coincide and only appear at rest
    a_r12_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (!q.err && q.state == S_IDLE));
endmodule

// File: tb/tb_clkdiv_step_seq.sv
module tb_clkdiv_step_seq;
    localparam longint unsigned HZ     = 100_000_000;
    localparam int              MARGIN = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] idx = 3'd0;
    logic [2:0] code;
    logic [6:0] rcnt;
    logic       sref, busy, done, err;

    always #2 clk = ~clk;

    clkdiv_step_seq #(.CORE_HZ(HZ), .PLL_LOCK_CYC(16), .DRAIN_MARGIN(MARGIN)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ratio_idx_i(idx),
        .div_code_o(code), .refresh_cnt_o(rcnt), .self_refresh_o(sref),
        .busy_o(busy), .done_o(done), .err_o(err)
    );

    // event fields: 0 divider, 1 refresh count, 2 self-refresh, 3 done, 4 error
    typedef struct { int f; int v; int gap; string tag; } evt_t;
    evt_t exp_q[$];

    int vectors = 0, fails = 0, cyc = 0, last_evt = 0, wd = 0;
    bit mon_on = 0;
    int m_idx = 0, m_ref = 0, m_sref = 0;
    bit last_div = 0;
    logic [2:0] p_code; logic [6:0] p_rcnt; logic p_sref;

    function automatic int bcode(int i);
        case (i) 0: return 0; 1: return 1; 2: return 3; 3: return 2; default: return 4; endcase
    endfunction
    function automatic int bdiv(int i);
        case (i) 0: return 1; 1: return 2; 2: return 4; 3: return 6; default: return 8; endcase
    endfunction
    function automatic int bref(int i);
        return int'((HZ * 64'd7800) / (64 * longint'(bdiv(i)) * 64'd1_000_000_000));
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic push(int f, int v, int g, string tag);
        exp_q.push_back('{f: f, v: v, gap: g, tag: tag});
    endtask

    task automatic model_step(int ns);
        int od, nd, nr, g0, dr;
        od = bdiv(m_idx); nd = bdiv(ns); nr = bref(ns);
        g0 = last_div ? 17 : 1;
        dr = 64 * (m_ref + nr) * od + MARGIN + 1;
        if (od == 2 && nd == 1) begin
            push(2, 0, g0, "R5 sref off first");
            push(0, bcode(ns), 1, "R5 divider second");
            push(1, nr, 17, "R5/R8/R9 refresh last");
            m_sref = 0; last_div = 0;
        end else if (od == 1 && nd == 2) begin
            push(1, nr, g0, "R6/R9 refresh first");
            push(0, bcode(ns), m_sref ? 1 : dr, "R6/R10 divider after drain");
            push(2, 1, 17, "R6/R8 sref on last");
            m_sref = 1; last_div = 0;
        end else if (nd > od) begin
            push(1, nr, g0, "R7/R9 slow refresh first");
            push(0, bcode(ns), m_sref ? 1 : dr, "R7 slow divider second");
            last_div = 1;
        end else begin
            push(0, bcode(ns), g0, "R7 fast divider first");
            push(1, nr, 17, "R7/R8 fast refresh second");
            last_div = 0;
        end
        m_idx = ns; m_ref = nr;
    endtask

    task automatic model_req(int t);
        last_div = 0;
        if (t > 4) push(4, 1, 1, "R2 error pulse");
        else if (t == m_idx) push(3, 1, 1, "R3 same index done");
        else begin
            while (m_idx != t) begin
                if ((m_idx == 0 && t > 1) || (m_idx > 1 && t == 0)) model_step(1);
                else model_step(t);
            end
            push(3, 1, last_div ? 17 : 1, "R12 done after last op");
        end
    endtask

    task automatic evt(int f, int v);
        evt_t e;
        vectors++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R4 unexpected event field=%0d actual=%0d expected=none", f, v);
        end else begin
            e = exp_q.pop_front();
            if (e.f != f || e.v != v || (cyc - last_evt) < e.gap) begin
                fails++;
                $display("FAIL %s actual field=%0d val=%0d gap=%0d expected field=%0d val=%0d gap>=%0d",
                         e.tag, f, v, cyc - last_evt, e.f, e.v, e.gap);
            end
        end
        last_evt = cyc;
    endtask

    // monitor: turns every visible output change into an event
    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            if (code != p_code) evt(0, int'(code));
            if (rcnt != p_rcnt) evt(1, int'(rcnt));
            if (sref != p_sref) evt(2, int'(sref));
            if (done) evt(3, 1);
            if (err)  evt(4, 1);
        end
        p_code = code; p_rcnt = rcnt; p_sref = sref;
    end

    task automatic do_req(int t, bit poke, int pidx);
        bit moves;
        moves = (t <= 4) && (t != m_idx);
        model_req(t);
        @(negedge clk); start = 1'b1; idx = 3'(t);
        @(negedge clk); start = 1'b0;
        if (moves) chk(busy == 1'b1, "R11 busy after start", int'(busy), 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1; idx = 3'(pidx);
            @(negedge clk); start = 1'b0;
        end
        while (exp_q.size() != 0 || busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                fails++;
                $display("FAIL watchdog expired actual=%0d expected<=150000", wd);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(code == 3'b000, "R1 reset code", int'(code), 0);
        chk(int'(rcnt) == bref(0), "R1/R9 reset refresh", int'(rcnt), bref(0));
        chk(sref == 1'b0, "R1 reset sref", int'(sref), 0);
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        chk(done == 1'b0, "R1 reset done", int'(done), 0);
        chk(err == 1'b0, "R1 reset err", int'(err), 0);
        m_idx = 0; m_ref = bref(0); m_sref = 0;
        mon_on = 1;
        do_req(1, 0, 0);   // R6 R10: 1->2 with drain
        do_req(2, 0, 0);   // R7 slower, self-refresh on
        do_req(4, 0, 0);   // R7 slower to 8
        do_req(3, 0, 0);   // R7 faster 8->6
        do_req(0, 0, 0);   // R4 R5 6->2->1
        do_req(4, 0, 0);   // R4 R10 1->2->8
        do_req(4, 0, 0);   // R3 same index
        do_req(7, 0, 0);   // R2 illegal index
        do_req(5, 0, 0);   // R2 illegal index
        do_req(2, 1, 0);   // R11 start while busy ignored
        do_req(0, 0, 0);   // R4 R5 4->2->1
        chk(exp_q.size() == 0, "R12 no pending events", exp_q.size(), 0);
        chk(code == 3'b000 && sref == 1'b0, "R6 final rest state", int'(code), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule